// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table in memory. It splits a 32-bit logical address into a 12-bit top index, a 10-bit second index and a 10-bit page offset. It fetches the top-level entry from the table base plus four times the top index. That entry names the second-level table, so the block then fetches the second-level entry. It returns the physical frame, or a fault report that says which level failed and why.

Memory is reached through a one-beat read port. The request is a single-cycle strobe with an address. The response comes back after any number of cycles, including in the same cycle as the request. Only one walk runs at a time. The request side sees a ready signal that stays low from acceptance until the result cycle has passed.

Each 32-bit entry uses bit 0 as present, bit 1 as write-permitted and bits 31:10 as a frame number. A top-level frame number, shifted left by 10, is the byte base of the second-level table.

Top module: `ptw_top`

## Requirements
- R1: After reset, walkReady is 1, memReqValid is 0 and doneValid is 0.
- R2: The first memory read address is tableBase + 4 × walkVaddr[31:20], using the values captured when the walk was accepted. Each level's read strobe memReqValid is high for exactly one cycle, so a successful walk asserts it for two cycles in total.
- R3: The second read address is (topEntry[31:10] << 10) + 4 × walkVaddr[19:10].
- R4: A successful walk reports doneFault = 0, doneFrame = leafEntry[31:10] and donePaddr = {leafEntry[31:10], walkVaddr[9:0]}.
- R5: A top-level entry with bit 0 clear gives doneFault = 1, doneFaultLevel = 0 (top level) and doneFaultKind = 0 (not present). No second read is issued.
- R6: A leaf entry with bit 0 clear gives doneFault = 1, doneFaultLevel = 1 (leaf level) and doneFaultKind = 0.
- R7: A write walk (walkIsWrite = 1) through an entry with bit 1 clear gives doneFaultKind = 1 (permission) at that entry's level, and a top-level permission fault issues no second read. A read walk never reports a permission fault. At a single level, a clear bit 0 wins over a clear bit 1.
- R8: A response arriving in the same cycle as its request is taken. With zero wait cycles, doneValid is high in the third cycle after acceptance, and any added latency leaves the result unchanged.
- R9: walkReady is 0 from the cycle after acceptance until the result cycle has passed. Requests made while busy are ignored and do not change the walk in progress.
- R10: doneValid is a single-cycle pulse followed by walkReady = 1. A response that arrives while no read is outstanding has no effect.
- R11: When doneFault = 1, donePaddr and doneFrame are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkReq | input | 1 | Start a walk; taken when walkReady is high |
| walkVaddr | input | 32 | Logical address to translate |
| walkIsWrite | input | 1 | Access is a write |
| tableBase | input | 32 | Byte address of the top-level table |
| walkReady | output | 1 | Walker idle and able to take a request |
| memReqValid | output | 1 | One-cycle memory read strobe |
| memReqAddr | output | 32 | Memory read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (page table entry) |
| doneValid | output | 1 | Result valid for one cycle |
| doneFault | output | 1 | Walk ended in a fault |
| doneFaultLevel | output | 1 | 0 = top level, 1 = leaf level |
| doneFaultKind | output | 1 | 0 = not present, 1 = permission |
| doneFrame | output | 22 | Translated frame number |
| donePaddr | output | 32 | Translated physical address |

## Verification
On every cycle the assertions check the handshake timing. A read strobe that gets no response in its own cycle must drop in the next. Ready must fall right after acceptance. The result must be a one-cycle pulse followed by idle, and a result can only appear just after a memory response. The bench scenarios are needed for the values themselves: the computed table addresses, the frame and physical address, which level and kind of fault is reported, the priority between the two fault kinds, and that requests and responses arriving at the wrong time leave the walk unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int OUTER_W   = 12;
  localparam int INNER_W   = 10;
  localparam int OFFSET_W  = 10;
  localparam int PTE_W     = 32;
  localparam int FRAME_W   = PTE_W - OFFSET_W;
  localparam int VALID_BIT = 0;
  localparam int WRITE_BIT = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_OUT, S_WT_OUT, S_RD_IN, S_WT_IN, S_DONE
  } walkState_t;

  typedef enum logic { LVL_OUTER = 1'b0, LVL_INNER = 1'b1 } faultLevel_t;
  typedef enum logic { KIND_INVALID = 1'b0, KIND_PROT = 1'b1 } faultKind_t;

  typedef struct packed {
    logic        ldWalk;
    logic        ldOuter;
    logic        ldInner;
    logic        setFault;
    faultLevel_t level;
    faultKind_t  kind;
    logic        selInner;
  } walkCtrl_t;

  typedef struct packed {
    logic entryInvalid;
    logic permDeny;
  } entryCheck_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        walkReq,
  input  logic        memRspValid,
  input  entryCheck_t chk,
  output walkCtrl_t   ctl,
  output logic        walkReady,
  output logic        memReqValid,
  output logic        doneValid
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_IDLE: begin
        if (walkReq) begin
          ctl.ldWalk = 1'b1;
          nextState  = S_RD_OUT;
        end
      end
      S_RD_OUT, S_WT_OUT: begin
        if (memRspValid) begin
          if (chk.entryInvalid) begin
            ctl.setFault = 1'b1;
            ctl.level    = LVL_OUTER;
            ctl.kind     = KIND_INVALID;
            nextState    = S_DONE;
          end else if (chk.permDeny) begin
            ctl.setFault = 1'b1;
            ctl.level    = LVL_OUTER;
            ctl.kind     = KIND_PROT;
            nextState    = S_DONE;
          end else begin
            ctl.ldOuter = 1'b1;
            nextState   = S_RD_IN;
          end
        end else if (state == S_RD_OUT) begin
          nextState = S_WT_OUT;
        end
      end
      S_RD_IN, S_WT_IN: begin
        ctl.selInner = 1'b1;
        if (memRspValid) begin
          nextState = S_DONE;
          if (chk.entryInvalid) begin
            ctl.setFault = 1'b1;
            ctl.level    = LVL_INNER;
            ctl.kind     = KIND_INVALID;
          end else if (chk.permDeny) begin
            ctl.setFault = 1'b1;
            ctl.level    = LVL_INNER;
            ctl.kind     = KIND_PROT;
          end else begin
            ctl.ldInner = 1'b1;
          end
        end else if (state == S_RD_IN) begin
          nextState = S_WT_IN;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign walkReady   = (state == S_IDLE);
  assign memReqValid = (state == S_RD_OUT) || (state == S_RD_IN);
  assign doneValid   = (state == S_DONE);

  // R2: a read strobe that is not answered in its own cycle drops next cycle
  p_one_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> !memReqValid);
  // R9: acceptance removes ready on the following cycle
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && walkReady |=> !walkReady);
  // R10: result is a single pulse followed by idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && walkReady);
  // R8: a result only ever follows a memory response
  p_done_after_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneValid) |-> $past(memRspValid));
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int  ADDR_W           = VA_W,
  parameter int  OUT_IDX_W        = OUTER_W,
  parameter int  IN_IDX_W         = INNER_W,
  parameter int  OFF_W            = OFFSET_W,
  parameter int  ENTRY_W          = PTE_W,
  parameter bit  CHECK_OUTER_PERM = 1'b1,
  localparam int FRM_W            = ENTRY_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkCtrl_t          ctl,
  input  logic [ADDR_W-1:0]  walkVaddr,
  input  logic               walkIsWrite,
  input  logic [ADDR_W-1:0]  tableBase,
  input  logic [ENTRY_W-1:0] memRspData,
  output entryCheck_t        chk,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic               doneFault,
  output logic               doneFaultLevel,
  output logic               doneFaultKind,
  output logic [FRM_W-1:0]   doneFrame,
  output logic [ADDR_W-1:0]  donePaddr
);
  logic [ADDR_W-1:0] vaddrReg;
  logic [ADDR_W-1:0] baseReg;
  logic              writeReg;
  logic [FRM_W-1:0]  innerBaseReg;
  logic [FRM_W-1:0]  frameReg;
  logic              faultReg;
  faultLevel_t       levelReg;
  faultKind_t        kindReg;

  logic [OUT_IDX_W-1:0] outerIdx;
  logic [IN_IDX_W-1:0]  innerIdx;
  logic [ADDR_W-1:0]    outerAddr, innerAddr, innerBase;
  logic                 writeDenied;

  assign outerIdx  = vaddrReg[ADDR_W-1 -: OUT_IDX_W];
  assign innerIdx  = vaddrReg[OFF_W +: IN_IDX_W];
  assign innerBase = {innerBaseReg, {OFF_W{1'b0}}};
  assign outerAddr = baseReg + ADDR_W'({outerIdx, 2'b00});
  assign innerAddr = innerBase + ADDR_W'({innerIdx, 2'b00});
  assign memReqAddr = ctl.selInner ? innerAddr : outerAddr;

  assign writeDenied      = writeReg && !memRspData[WRITE_BIT];
  assign chk.entryInvalid = !memRspData[VALID_BIT];

  generate
    if (CHECK_OUTER_PERM) begin : g_perm_both
      assign chk.permDeny = writeDenied;
    end else begin : g_perm_leaf
      assign chk.permDeny = writeDenied && ctl.selInner;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrReg     <= '0;
      baseReg      <= '0;
      writeReg     <= 1'b0;
      innerBaseReg <= '0;
      frameReg     <= '0;
      faultReg     <= 1'b0;
      levelReg     <= LVL_OUTER;
      kindReg      <= KIND_INVALID;
    end else begin
      if (ctl.ldWalk) begin
        vaddrReg <= walkVaddr;
        baseReg  <= tableBase;
        writeReg <= walkIsWrite;
        frameReg <= '0;
        faultReg <= 1'b0;
        levelReg <= LVL_OUTER;
        kindReg  <= KIND_INVALID;
      end
      if (ctl.ldOuter) innerBaseReg <= memRspData[ENTRY_W-1 -: FRM_W];
      if (ctl.ldInner) frameReg     <= memRspData[ENTRY_W-1 -: FRM_W];
      if (ctl.setFault) begin
        faultReg <= 1'b1;
        levelReg <= ctl.level;
        kindReg  <= ctl.kind;
      end
    end
  end

  assign doneFault      = faultReg;
  assign doneFaultLevel = levelReg;
  assign doneFaultKind  = kindReg;
  assign doneFrame      = faultReg ? '0 : frameReg;
  assign donePaddr      = faultReg ? '0 : {frameReg, vaddrReg[OFF_W-1:0]};
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter bit CHECK_OUTER_PERM = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                walkReq,
  input  logic [VA_W-1:0]     walkVaddr,
  input  logic                walkIsWrite,
  input  logic [VA_W-1:0]     tableBase,
  output logic                walkReady,
  output logic                memReqValid,
  output logic [VA_W-1:0]     memReqAddr,
  input  logic                memRspValid,
  input  logic [PTE_W-1:0]    memRspData,
  output logic                doneValid,
  output logic                doneFault,
  output logic                doneFaultLevel,
  output logic                doneFaultKind,
  output logic [FRAME_W-1:0]  doneFrame,
  output logic [VA_W-1:0]     donePaddr
);
  walkCtrl_t   ctl;
  entryCheck_t chk;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .walkReq     (walkReq),
    .memRspValid (memRspValid),
    .chk         (chk),
    .ctl         (ctl),
    .walkReady   (walkReady),
    .memReqValid (memReqValid),
    .doneValid   (doneValid)
  );

  ptw_dpath #(.CHECK_OUTER_PERM(CHECK_OUTER_PERM)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .walkVaddr      (walkVaddr),
    .walkIsWrite    (walkIsWrite),
    .tableBase      (tableBase),
    .memRspData     (memRspData),
    .chk            (chk),
    .memReqAddr     (memReqAddr),
    .doneFault      (doneFault),
    .doneFaultLevel (doneFaultLevel),
    .doneFaultKind  (doneFaultKind),
    .doneFrame      (doneFrame),
    .donePaddr      (donePaddr)
  );
endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkReq = 1'b0;
  logic [31:0] walkVaddr = '0;
  logic        walkIsWrite = 1'b0;
  logic [31:0] tableBase = '0;
  logic        walkReady, memReqValid, memRspValid;
  logic [31:0] memReqAddr;
  logic [31:0] memRspData;
  logic        doneValid, doneFault, doneFaultLevel, doneFaultKind;
  logic [21:0] doneFrame;
  logic [31:0] donePaddr;

  logic        rspDrv = 1'b0, spurDrv = 1'b0;
  logic [31:0] rspData = '0;
  int          latency = 0;
  logic [31:0] expOuter = '0, expInner = '0, outerEntry = '0, innerEntry = '0;
  int          reqCycles = 0;
  logic        badAddr = 1'b0;
  int          nChecks = 0, nFails = 0;

  logic        rFault, rLevel, rKind;
  logic [21:0] rFrame;
  logic [31:0] rPaddr;
  int          rCycles;

  assign memRspValid = rspDrv | spurDrv;
  assign memRspData  = rspData;

  always #10 clk = ~clk;

  ptw_top u0 (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .walkVaddr(walkVaddr),
    .walkIsWrite(walkIsWrite), .tableBase(tableBase), .walkReady(walkReady),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .doneValid(doneValid), .doneFault(doneFault),
    .doneFaultLevel(doneFaultLevel), .doneFaultKind(doneFaultKind),
    .doneFrame(doneFrame), .donePaddr(donePaddr)
  );

  // memory model: answers each strobe after 'latency' cycles
  initial begin
    int pend;
    logic [31:0] lastAddr;
    pend = -1;
    lastAddr = '0;
    forever begin
      @(negedge clk);
      rspDrv = 1'b0;
      if (memReqValid) begin
        reqCycles++;
        if (pend < 0) begin
          lastAddr = memReqAddr;
          pend = latency;
        end
      end
      if (pend == 0) begin
        rspDrv = 1'b1;
        if (lastAddr == expOuter)      rspData = outerEntry;
        else if (lastAddr == expInner) rspData = innerEntry;
        else begin rspData = '0; badAddr = 1'b1; end
        pend = -1;
      end else if (pend > 0) begin
        pend--;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runWalk(input logic [31:0] va, input logic wr, input logic [31:0] base,
                         input logic [31:0] oEnt, input logic [31:0] iEnt, input int lat,
                         input bit pokeBusy);
    latency    = lat;
    outerEntry = oEnt;
    innerEntry = iEnt;
    expOuter   = base + {18'd0, va[31:20], 2'b00};
    expInner   = {oEnt[31:10], 10'd0} + {20'd0, va[19:10], 2'b00};
    reqCycles  = 0;
    badAddr    = 1'b0;
    @(negedge clk);
    walkReq = 1'b1; walkVaddr = va; walkIsWrite = wr; tableBase = base;
    @(negedge clk);
    walkReq = 1'b0;
    rCycles = 1;
    while (!doneValid && rCycles < 500) begin
      if (pokeBusy) begin
        check(walkReady == 1'b0, "R9 ready low while busy", {31'd0, walkReady}, 32'd0);
        walkReq = 1'b1; walkVaddr = 32'hFFFF_FFFF; walkIsWrite = ~wr; tableBase = 32'h0BAD_0000;
      end
      @(negedge clk);
      rCycles++;
    end
    walkReq = 1'b0;
    rFault = doneFault; rLevel = doneFaultLevel; rKind = doneFaultKind;
    rFrame = doneFrame; rPaddr = donePaddr;
    @(negedge clk);
    check(doneValid == 1'b0 && walkReady == 1'b1, "R10 pulse then idle",
          {30'd0, doneValid, walkReady}, 32'd1);
  endtask

  task automatic expectGood(input string tag, input logic [31:0] va, input logic [31:0] iEnt, input int reqs);
    check(rFault == 1'b0, {tag, " R4 no fault"}, {31'd0, rFault}, 32'd0);
    check(rFrame == iEnt[31:10], {tag, " R4 frame"}, {10'd0, rFrame}, {10'd0, iEnt[31:10]});
    check(rPaddr == {iEnt[31:10], va[9:0]}, {tag, " R4 paddr"}, rPaddr, {iEnt[31:10], va[9:0]});
    check(!badAddr, {tag, " R2 R3 table addresses"}, {31'd0, badAddr}, 32'd0);
    check(reqCycles == reqs, {tag, " R2 strobe cycles"}, reqCycles, reqs);
  endtask

  task automatic expectFault(input string tag, input logic lvl, input logic kind, input int reqs);
    check(rFault == 1'b1, {tag, " fault flag"}, {31'd0, rFault}, 32'd1);
    check(rLevel == lvl, {tag, " level"}, {31'd0, rLevel}, {31'd0, lvl});
    check(rKind == kind, {tag, " kind"}, {31'd0, rKind}, {31'd0, kind});
    check(rPaddr == 0 && rFrame == 0, {tag, " R11 zero result"}, rPaddr, 32'd0);
    check(!badAddr, {tag, " R2 R3 table addresses"}, {31'd0, badAddr}, 32'd0);
    check(reqCycles == reqs, {tag, " read count"}, reqCycles, reqs);
  endtask

  task automatic testReset;
    check(walkReady == 1'b1, "R1 ready", {31'd0, walkReady}, 32'd1);
    check(memReqValid == 1'b0, "R1 no read", {31'd0, memReqValid}, 32'd0);
    check(doneValid == 1'b0, "R1 no result", {31'd0, doneValid}, 32'd0);
  endtask

  task automatic testReadZeroWait; // R2 R3 R4 R8
    runWalk(32'hABC5_5A7E, 1'b0, 32'h0010_0000, 32'h0123_4401, 32'h00AB_CC01, 0, 1'b0);
    expectGood("read lat0", 32'hABC5_5A7E, 32'h00AB_CC01, 2);
    check(rCycles == 3, "R8 zero-wait result cycle", rCycles, 3);
  endtask

  task automatic testWriteSlow; // R4 R8
    runWalk(32'h0017_F3FF, 1'b1, 32'h8000_0400, 32'hFFFF_FC03, 32'h5555_5403, 3, 1'b0);
    expectGood("write lat3", 32'h0017_F3FF, 32'h5555_5403, 2);
  endtask

  task automatic testOuterInvalid; // R5
    runWalk(32'h4000_0000, 1'b0, 32'h0000_2000, 32'h0123_4402, 32'h0, 1, 1'b0);
    expectFault("R5 top absent", 1'b0, 1'b0, 1);
  endtask

  task automatic testInnerInvalid; // R6
    runWalk(32'h0020_0C00, 1'b0, 32'h0000_3000, 32'h0002_0001, 32'h0FFF_FC02, 2, 1'b0);
    expectFault("R6 leaf absent", 1'b1, 1'b0, 2);
  endtask

  task automatic testProtection; // R7
    runWalk(32'h1234_5678, 1'b1, 32'h0004_0000, 32'h0777_0001, 32'h0, 0, 1'b0);
    expectFault("R7 top perm", 1'b0, 1'b1, 1);
    runWalk(32'h1234_5678, 1'b1, 32'h0004_0000, 32'h0777_0003, 32'h3333_3001, 1, 1'b0);
    expectFault("R7 leaf perm", 1'b1, 1'b1, 2);
    runWalk(32'h1234_5678, 1'b0, 32'h0004_0000, 32'h0777_0001, 32'h3333_3001, 1, 1'b0);
    expectGood("R7 read ignores perm", 32'h1234_5678, 32'h3333_3001, 2);
    runWalk(32'h1234_5678, 1'b1, 32'h0004_0000, 32'h0777_0000, 32'h0, 0, 1'b0);
    expectFault("R7 absent beats perm", 1'b0, 1'b0, 1);
  endtask

  task automatic testBackpressure; // R9
    runWalk(32'h8765_4321, 1'b0, 32'h0200_0000, 32'h0444_4001, 32'h0999_9001, 4, 1'b1);
    expectGood("R9 busy requests ignored", 32'h8765_4321, 32'h0999_9001, 2);
  endtask

  task automatic testSpurious; // R10
    @(negedge clk);
    spurDrv = 1'b1;
    repeat (2) @(negedge clk);
    spurDrv = 1'b0;
    check(doneValid == 1'b0 && walkReady == 1'b1 && memReqValid == 1'b0,
          "R10 stray response ignored", {29'd0, doneValid, walkReady, memReqValid}, 32'd2);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadZeroWait();
    testWriteSlow();
    testOuterInvalid();
    testInnerInvalid();
    testProtection();
    testBackpressure();
    testSpurious();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule